// File: doc/BRIEF.md
# Two-Phase Register Machine with Streamed Input and Output

This block is a small multi-cycle processor. It reads 16-bit instruction words from a program memory outside the block. That memory is purely combinational and has an 8-bit address. The processor works on four general registers of 8 bits each. Every instruction takes one fetch cycle and then one execute cycle.

Data comes in through an input port that uses a valid signal. An instruction that reads the input waits until valid is present, and it acknowledges the value in the cycle it takes it. Results go out through a registered output port that carries a one-cycle strobe. The processor keeps a zero flag and a negative flag. A compare-style instruction sets these flags, and conditional jumps later act on them.

A typical use is a short routine that reads a stream of signed bytes and skips the negative ones. It accumulates the squares of the first five non-negative values and then keeps presenting the total.

Top module: `tacc_cpu`

## Requirements
- R1: While rst_n is low, imem_addr is 0 and out_valid is 0. After reset, all four registers read 0 and both flags are clear, so a zero-conditional jump executed first falls through.
- R2: An instruction word is split into an opcode in bits [15:12], a source register select in bits [11:10], a destination register select in bits [9:8], and an immediate or target in bits [7:0]. Each instruction takes exactly two cycles: a fetch that increments the program counter, then an execute. A two-instruction loop therefore repeats every 4 cycles.
- R3: Opcode 0001 loads the zero-extended immediate into the destination register. Opcode 1001 copies the source register to out_data and raises out_valid for exactly one cycle.
- R4: Opcode 0010 holds in execute, with imem_addr unchanged and in_ack low, for as long as in_valid is low. In the cycle in_valid is high, in_ack is high and in_data is written to the destination register.
- R5: Opcode 0110 writes destination plus source, opcode 0101 writes source times source, and opcode 0111 writes destination minus one. All three results are taken modulo 256, so decrementing 0 gives 0xFF.
- R6: Opcode 0011 sets the zero flag when the source register is 0 and copies its bit 7 into the negative flag. It writes no register. Opcodes 0110, 0101 and 0111 update the zero flag from their result and leave the negative flag unchanged.
- R7: Opcode 1000 jumps to bits [7:0] when the zero flag is set. Opcode 0100 jumps there when the negative flag is set. Opcode 1010 always jumps there. A conditional jump whose flag is clear falls through to the next address.
- R8: Opcodes 0000 and 1011 through 1111 change no register and no flag; they only advance the program counter.
- R9: Running the square-sum routine, the output equals the sum modulo 256 of the squares of the first five inputs whose bit 7 is 0. Inputs with bit 7 set are consumed and ignored. The total is then presented again on every later output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| imem_addr | output | 8 | Program counter, address to the program memory |
| imem_data | input | 16 | Instruction word at imem_addr, same cycle |
| in_data | input | 8 | Input value |
| in_valid | input | 1 | Input value present |
| in_ack | output | 1 | Input value taken on this clock edge |
| out_data | output | 8 | Last value sent out |
| out_valid | output | 1 | One-cycle strobe marking a new out_data |

## Verification
The assertions assume that the program memory returns a settled word for imem_addr within the same cycle. They also assume that in_valid and in_data are known values at every rising edge and change only between edges. The stimulus changes inputs only on falling edges. It holds in_valid and in_data steady until in_ack has been seen, then drops in_valid. Program contents change only while reset is held.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  localparam int DATA_W  = 8;
  localparam int PC_W    = 8;
  localparam int REG_N   = 4;
  localparam int OPC_W   = 4;
  localparam int RSEL_W  = 2;
  localparam int IMM_W   = 8;
  localparam int INSTR_W = OPC_W + 2 * RSEL_W + IMM_W;

  typedef enum logic [OPC_W-1:0] {
    OP_MOV  = 4'h1,
    OP_INT  = 4'h2,
    OP_TEST = 4'h3,
    OP_JB   = 4'h4,
    OP_MUL  = 4'h5,
    OP_ADD  = 4'h6,
    OP_DEC  = 4'h7,
    OP_JZ   = 4'h8,
    OP_OUT  = 4'h9,
    OP_JMP  = 4'hA
  } opcode_e;

  typedef struct packed {
    logic [OPC_W-1:0]  op;
    logic [RSEL_W-1:0] rs;
    logic [RSEL_W-1:0] rd;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;
endpackage

// File: rtl/tacc_regfile.sv
module tacc_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] asel,
  output logic [DW-1:0] adata,
  input  logic [SW-1:0] bsel,
  output logic [DW-1:0] bdata
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic [NREG-1:0][DW-1:0] regs_d;

  always_comb begin
    regs_d = regs_q;
    regs_d[wsel] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (we) begin
      regs_q <= regs_d;
    end
  end

  assign adata = regs_q[asel];
  assign bdata = regs_q[bsel];

  AST_IDLE_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q)); // R8
endmodule

// File: rtl/tacc_alu.sv
module tacc_alu
  import tacc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [OPC_W-1:0] op,
  input  logic [DW-1:0]    src,
  input  logic [DW-1:0]    dst,
  input  logic [DW-1:0]    ext_in,
  input  logic [IMM_W-1:0] imm,
  output logic [DW-1:0]    result,
  output logic             wr_en,
  output logic             z_upd,
  output logic             z_val,
  output logic             n_upd,
  output logic             n_val
);
  logic [DW-1:0] sq_lo;

  always_comb begin
    sq_lo  = src * src;
    result = '0;
    wr_en  = 1'b0;
    z_upd  = 1'b0;
    n_upd  = 1'b0;
    n_val  = src[DW-1];
    case (op)
      OP_MOV:  begin result = DW'(imm);           wr_en = 1'b1; end
      OP_INT:  begin result = ext_in;             wr_en = 1'b1; end
      OP_MUL:  begin result = sq_lo;              wr_en = 1'b1; z_upd = 1'b1; end
      OP_ADD:  begin result = dst + src;          wr_en = 1'b1; z_upd = 1'b1; end
      OP_DEC:  begin result = dst - DW'(1);       wr_en = 1'b1; z_upd = 1'b1; end
      OP_TEST: begin result = src;                z_upd = 1'b1; n_upd = 1'b1; end
      default: begin result = '0; end
    endcase
    z_val = (result == '0);
  end
endmodule

// File: rtl/tacc_ctrl.sv
module tacc_ctrl
  import tacc_pkg::*;
#(
  parameter int PW = PC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] fetch_word,
  input  logic               in_valid,
  input  logic               z_upd,
  input  logic               z_val,
  input  logic               n_upd,
  input  logic               n_val,
  output logic [PW-1:0]      pc,
  output instr_t             ir,
  output logic               exec_en
);
  phase_e        phase_q, phase_d;
  logic [PW-1:0] pc_q, pc_d;
  instr_t        ir_q, ir_d;
  logic          zf_q, zf_d, nf_q, nf_d;
  logic          stall, take;

  always_comb begin
    phase_d = phase_q;
    pc_d    = pc_q;
    ir_d    = ir_q;
    zf_d    = zf_q;
    nf_d    = nf_q;
    take    = 1'b0;
    stall   = (phase_q == PH_EXEC) && (ir_q.op == OP_INT) && !in_valid;
    exec_en = (phase_q == PH_EXEC) && !stall;
    if (phase_q == PH_FETCH) begin
      ir_d    = instr_t'(fetch_word);
      pc_d    = pc_q + PW'(1);
      phase_d = PH_EXEC;
    end else if (exec_en) begin
      phase_d = PH_FETCH;
      if (z_upd) zf_d = z_val;
      if (n_upd) nf_d = n_val;
      case (ir_q.op)
        OP_JMP:  take = 1'b1;
        OP_JZ:   take = zf_q;
        OP_JB:   take = nf_q;
        default: take = 1'b0;
      endcase
      if (take) pc_d = PW'(ir_q.imm);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      zf_q    <= 1'b0;
      nf_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      zf_q    <= zf_d;
      nf_q    <= nf_d;
    end
  end

  assign pc = pc_q;
  assign ir = ir_q;

  AST_FETCH_STEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC) && (pc_q == $past(pc_q) + PW'(1))); // R2
  AST_INPUT_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc_q) && (phase_q == PH_EXEC)); // R4
  AST_JUMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && ir_q.op == OP_JMP) |=> (pc_q == PW'($past(ir_q.imm)))); // R7
  AST_FLAGS_QUIET_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FETCH) |=> $stable({zf_q, nf_q})); // R6
endmodule

// File: rtl/tacc_cpu.sv
module tacc_cpu
  import tacc_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int PW   = PC_W,
  parameter int NREG = REG_N
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PW-1:0]      imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  input  logic [DW-1:0]      in_data,
  input  logic               in_valid,
  output logic               in_ack,
  output logic [DW-1:0]      out_data,
  output logic               out_valid
);
  localparam int SW = $clog2(NREG);

  logic          rst_meta_q, rst_sync_q, rst_ni;
  instr_t        ir;
  logic          exec_en, emit;
  logic [DW-1:0] src_val, dst_val, alu_res;
  logic          alu_we, z_upd, z_val, n_upd, n_val;
  logic          out_valid_q;
  logic [DW-1:0] out_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_ni = rst_sync_q;

  tacc_ctrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .fetch_word(imem_data), .in_valid(in_valid),
    .z_upd(z_upd), .z_val(z_val), .n_upd(n_upd), .n_val(n_val),
    .pc(imem_addr), .ir(ir), .exec_en(exec_en)
  );

  tacc_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_ni), .we(exec_en && alu_we),
    .wsel(SW'(ir.rd)), .wdata(alu_res),
    .asel(SW'(ir.rs)), .adata(src_val),
    .bsel(SW'(ir.rd)), .bdata(dst_val)
  );

  tacc_alu #(.DW(DW)) u_alu (
    .op(ir.op), .src(src_val), .dst(dst_val), .ext_in(in_data), .imm(ir.imm),
    .result(alu_res), .wr_en(alu_we), .z_upd(z_upd), .z_val(z_val),
    .n_upd(n_upd), .n_val(n_val)
  );

  assign in_ack = exec_en && (ir.op == OP_INT);
  assign emit   = exec_en && (ir.op == OP_OUT);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_q <= '0;
    end else if (emit) begin
      out_data_q <= src_val;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  AST_OUT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |=> !out_valid); // R3
  AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    in_ack |=> !in_ack); // R4
  AST_OUT_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_ni)
    !emit |=> $stable(out_data)); // R3
endmodule

// File: tb/test_tacc_cpu.sv
`timescale 1ns/1ps
module test_tacc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ack;
  logic [7:0]  out_data;
  logic        out_valid;
  logic [15:0] prog [0:31];
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  assign imem_data = (imem_addr < 8'd32) ? prog[imem_addr[4:0]] : 16'h0000;

  tacc_cpu i_tacc_cpu (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .in_data(in_data), .in_valid(in_valid), .in_ack(in_ack),
    .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    foreach (prog[i]) prog[i] = 16'h0000;
  endtask

  task automatic reset_dut();
    in_valid = 1'b0;
    in_data  = 8'h00;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    check(imem_addr == 8'h00, "R1", "address in reset", imem_addr, 0);
    check(out_valid == 1'b0, "R1", "strobe in reset", out_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_out(output logic [7:0] v, output bit got);
    got = 1'b0;
    v   = 8'h00;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (out_valid) begin
        got = 1'b1;
        v   = out_data;
      end
    end
  endtask

  task automatic expect_out(input string req, input logic [7:0] exp);
    logic [7:0] v;
    bit got;
    wait_out(v, got);
    check(got, req, "output strobe seen", got, 1);
    check(v == exp, req, "output value", v, exp);
  endtask

  task automatic feed(input logic [7:0] v);
    bit took = 1'b0;
    in_data  = v;
    in_valid = 1'b1;
    for (int i = 0; i < 400 && !took; i++) begin
      #1;
      if (in_ack) took = 1'b1;
      else @(negedge clk);
    end
    check(took, "R4", "input accepted", took, 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R1: cleared registers and flags
  task automatic t_reset();
    clear_prog();
    prog[0] = 16'h8004; prog[1] = 16'h9800; prog[2] = 16'hA002;
    prog[4] = 16'h1277; prog[5] = 16'h9800; prog[6] = 16'hA006;
    reset_dut();
    expect_out("R1", 8'h00);
  endtask

  // R3 and R2: load, emit, pulse width and loop period
  task automatic t_mov_out();
    logic [7:0] v;
    bit got;
    int gap;
    clear_prog();
    prog[0] = 16'h11A5; prog[1] = 16'h9400; prog[2] = 16'hA001;
    reset_dut();
    wait_out(v, got);
    check(got && v == 8'hA5, "R3", "immediate sent out", v, 8'hA5);
    @(negedge clk);
    check(out_valid == 1'b0, "R3", "strobe width", out_valid, 0);
    gap = 1;
    while (!out_valid && gap < 20) begin
      @(negedge clk);
      gap++;
    end
    check(gap == 4, "R2", "cycles between loop outputs", gap, 4);
  endtask

  // R5: add, square, decrement with wrap
  task automatic t_arith();
    clear_prog();
    prog[0]  = 16'h1080; prog[1]  = 16'h1103; prog[2]  = 16'h5600;
    prog[3]  = 16'h6800; prog[4]  = 16'h7100; prog[5]  = 16'h9000;
    prog[6]  = 16'h9400; prog[7]  = 16'h9800; prog[8]  = 16'h1300;
    prog[9]  = 16'h7300; prog[10] = 16'h9C00; prog[11] = 16'h1314;
    prog[12] = 16'h5F00; prog[13] = 16'h9C00; prog[14] = 16'hA00E;
    reset_dut();
    expect_out("R5", 8'h89);
    expect_out("R5", 8'h02);
    expect_out("R5", 8'h09);
    expect_out("R5", 8'hFF);
    expect_out("R5", 8'h90);
  endtask

  // R6 and R7: flag setting and conditional jumps
  task automatic t_branch();
    clear_prog();
    prog[0]  = 16'h1000; prog[1]  = 16'h3000; prog[2]  = 16'h4006;
    prog[3]  = 16'h8005; prog[4]  = 16'h9000; prog[5]  = 16'h1181;
    prog[6]  = 16'h9400; prog[7]  = 16'h3400; prog[8]  = 16'h800B;
    prog[9]  = 16'h400C; prog[10] = 16'h0000; prog[11] = 16'h9000;
    prog[12] = 16'h9400; prog[13] = 16'h7000; prog[14] = 16'h4010;
    prog[15] = 16'h9400; prog[16] = 16'h9000; prog[17] = 16'h1180;
    prog[18] = 16'h6500; prog[19] = 16'h8015; prog[20] = 16'h9000;
    prog[21] = 16'h9400; prog[22] = 16'hA016;
    reset_dut();
    expect_out("R7", 8'h81);
    expect_out("R6", 8'h81);
    expect_out("R6", 8'hFF);
    expect_out("R7", 8'h00);
  endtask

  // R8: unused opcodes do nothing
  task automatic t_nop();
    clear_prog();
    prog[0] = 16'h103C; prog[1] = 16'h0FFF; prog[2] = 16'hB3FF;
    prog[3] = 16'hFE00; prog[4] = 16'h9000; prog[5] = 16'h9C00;
    prog[6] = 16'hA006;
    reset_dut();
    expect_out("R8", 8'h3C);
    expect_out("R8", 8'h00);
  endtask

  // R4: input wait holds the machine
  task automatic t_stall();
    logic [7:0] a0;
    int acks = 0;
    int outs = 0;
    clear_prog();
    prog[0] = 16'h2200; prog[1] = 16'h9800; prog[2] = 16'hA002;
    reset_dut();
    repeat (10) @(negedge clk);
    a0 = imem_addr;
    repeat (20) begin
      @(negedge clk);
      if (in_ack) acks++;
      if (out_valid) outs++;
    end
    check(imem_addr == a0 && a0 == 8'h01, "R4", "address held while waiting", imem_addr, 1);
    check(acks == 0 && outs == 0, "R4", "no ack or output while waiting", acks + outs, 0);
    feed(8'h5A);
    expect_out("R4", 8'h5A);
  endtask

  // R9: square-sum routine
  task automatic t_sumsq(input logic [7:0] vals [8], input int n);
    int cnt = 0;
    int sum = 0;
    clear_prog();
    prog[0]  = 16'h1300; prog[1]  = 16'h1105; prog[2]  = 16'h3400;
    prog[3]  = 16'h800B; prog[4]  = 16'h2200; prog[5]  = 16'h3800;
    prog[6]  = 16'h4002; prog[7]  = 16'h5A00; prog[8]  = 16'h6B00;
    prog[9]  = 16'h7100; prog[10] = 16'hA002; prog[11] = 16'h9C00;
    prog[12] = 16'hA00B;
    reset_dut();
    @(negedge clk);
    for (int i = 0; i < n && cnt < 5; i++) begin
      feed(vals[i]);
      if (!vals[i][7]) begin
        sum += int'(vals[i]) * int'(vals[i]);
        cnt++;
      end
    end
    expect_out("R9", 8'(sum));
    expect_out("R9", 8'(sum));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_mov_out();
    t_arith();
    t_branch();
    t_nop();
    t_stall();
    t_sumsq('{8'h03, 8'hFE, 8'h04, 8'h00, 8'h01, 8'h05, 8'h00, 8'h00}, 6);
    t_sumsq('{8'h0A, 8'h0C, 8'h80, 8'h07, 8'h09, 8'h0B, 8'h00, 8'h00}, 6);
    t_sumsq('{8'hFF, 8'hFF, 8'h02, 8'h02, 8'h02, 8'h02, 8'h02, 8'h00}, 7);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule